// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter held as two 8-bit halves, reached through a small register window on an 8-bit data bus. It counts one of two sources. The first is an internal tick, one per instruction cycle, which is the system clock divided by four. The second is the rising edges of an external clock input, sampled into the system clock domain. The chosen source goes through a prescaler that divides by 1, 2, 4 or 8. A run bit gates counting. When the count wraps from its maximum value to zero, a sticky overflow flag is raised. A special-event pulse from a neighbouring compare unit can clear the count.

The external path can be synchronized, which means a two-flop synchronizer before the edge detector. It can also be taken on the faster path, with the edge detector on the first flop only. That path is one system clock earlier. A wide-access mode makes 16-bit transfers atomic over the 8-bit bus:
- A write to the high address fills a holding buffer.
- A write to the low address loads both halves at once.
- A read of the low address copies the live high half into that buffer, so a later high read returns a value that matches it.

Top module: `ptmr16`

## Requirements
- R1: After reset, the control register, both counter halves, the high-byte buffer and the overflow flag read as zero. Register addresses: 0 control, 1 count low, 2 count high, 3 status (bit 0 = overflow flag).
- R2: With control bit 1 (source) at 0, the run bit (bit 0) at 1 and a prescale code of 0, the count rises by one every 4 system clocks. The first increment comes 4 clocks after a counter-byte write.
- R3: Control bits 4:3 hold the prescale code. Codes 0, 1, 2 and 3 divide the selected source by 1, 2, 4 and 8.
- R4: While the run bit is 0, the count holds its value whatever the internal tick or the external input does.
- R5: With the source bit at 1, each rising edge of the external input advances the prescaler. With control bit 2 at 1 (unsynchronized path), an edge reaches the count one system clock earlier than with bit 2 at 0.
- R6: An increment from 0xFFFF gives 0x0000 and sets the overflow flag. The flag stays set until any write to the status address. If a wrap and such a write fall in the same cycle, the flag is set.
- R7: A special-event pulse clears the count to 0x0000 without touching the flag. A counter-byte write in the same cycle takes precedence, and the pulse is then ignored.
- R8: With control bit 5 (wide mode) at 1, a high-address write fills only the buffer. A low-address write loads the low byte from the bus and the high byte from the buffer in one cycle.
- R9: In wide mode, a low-address read copies the live high byte into the buffer, and a high-address read returns the buffer rather than the live byte.
- R10: With wide mode at 0, high-address and low-address writes and reads act on the live halves directly.
- R11: A counter-byte write takes precedence over an increment in the same cycle. It also clears the prescaler and the internal tick divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | External count input, sampled by clk |
| sev_clr_i | input | 1 | Special-event clear pulse |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: 8-bit halves, an internal tick divider of 4, a 2-bit prescale code and a 2-stage synchronizer. With these values every prescale code can be run to a whole number of periods within a few dozen clocks. The one-clock gap between the synchronized and unsynchronized external paths can be seen in a single read. Preloading 0xFFFF lets a single external edge reach the wrap and the flag. The external input is stepped one clock at a time, so a bus write can be placed in the exact cycle of an increment.

// File: rtl/ptmr_pkg.sv
// Package: shared register addresses and the control register layout for
// the prescaled timer. Assumes a bus data width of at least 6 bits.
package ptmr_pkg;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_LO   = 2'd1;
    localparam logic [1:0] ADR_HI   = 2'd2;
    localparam logic [1:0] ADR_STAT = 2'd3;

    // Control register, bit 5 down to bit 0.
    typedef struct packed {
        logic       wide;      // bit 5: buffered 16-bit access
        logic [1:0] ps;        // bits 4:3: prescale code
        logic       async_sel; // bit 2: unsynchronized external path
        logic       ext_sel;   // bit 1: external source
        logic       run;       // bit 0: counting enable
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ptmr_clksel.sv
// Clock source selector: makes a one-cycle internal tick every TICK_DIV
// system clocks and detects rising edges of the sampled external input on
// either a synchronized (SYNC_W flops) or a single-flop path.
// Assumes SYNC_W >= 2 and that the external input is slower than clk / 2.
module ptmr_clksel #(
    parameter int TICK_DIV = 4,
    parameter int SYNC_W   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic run,
    input  logic ext_sel,
    input  logic async_sel,
    input  logic restart,
    output logic src_tick
);

    logic [SYNC_W:0] stg_q;
    logic            int_tick;
    logic            edge_fast;
    logic            edge_sync;

    // Purpose: shift the external input through the sampling chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[SYNC_W-1:0], ext_i};
    end

    assign edge_fast = stg_q[0] & ~stg_q[1];
    assign edge_sync = stg_q[SYNC_W-1] & ~stg_q[SYNC_W];

    generate
        if (TICK_DIV <= 1) begin : g_nodiv
            assign int_tick = 1'b1;
        end else begin : g_div
            localparam int DIV_W = $clog2(TICK_DIV);
            logic [DIV_W-1:0] div_q;

            // Purpose: free-running instruction-cycle divider, restarted on counter writes.
            always_ff @(posedge clk) begin
                if (!rst_n || restart)                   div_q <= '0;
                else if (div_q == DIV_W'(TICK_DIV - 1)) div_q <= '0;
                else                                     div_q <= div_q + 1'b1;
            end

            assign int_tick = (div_q == DIV_W'(TICK_DIV - 1));

            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                int_tick |=> !int_tick);                               // R2
        end
    endgenerate

    // Purpose: pick the source pulse and gate it with the run bit.
    always_comb begin
        if (!run)         src_tick = 1'b0;
        else if (ext_sel) src_tick = async_sel ? edge_fast : edge_sync;
        else              src_tick = int_tick;
    end

    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        edge_sync |-> $past(edge_fast, SYNC_W - 1));                   // R5
    AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !src_tick);                                           // R4

endmodule

// File: rtl/ptmr_prescale.sv
// Prescaler: passes every 2**sel-th input pulse. The internal count is
// cleared by restart and after each output pulse. A masked compare keeps
// it from sticking when the code is lowered in mid-count.
module ptmr_prescale #(
    parameter int PS_SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [PS_SEL_W-1:0] sel,
    input  logic                restart,
    output logic                tick_o
);

    localparam int PS_CNT_W = (1 << PS_SEL_W) - 1;

    logic [PS_CNT_W-1:0] cnt_q;
    logic [PS_CNT_W-1:0] limit;

    assign limit  = ~({PS_CNT_W{1'b1}} << sel);
    assign tick_o = tick_i && ((cnt_q & limit) == limit);

    // Purpose: count source pulses until the selected ratio is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (tick_o)       cnt_q <= '0;
        else if (tick_i)       cnt_q <= cnt_q + 1'b1;
    end

    AST_PS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && sel != '0 && !restart) |=> !tick_o);                // R3
    AST_PS_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> !tick_o);                                          // R3

endmodule

// File: rtl/ptmr_core.sv
// Counter core: two BYTE_W halves with bus write, special-event clear and
// increment (in that priority), the sticky wrap flag, and the high-byte
// buffer used for atomic access in wide mode.
// Assumes at most one of wr_lo / wr_hi / rd_lo per cycle.
module ptmr_core #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc,
    input  logic                  sev_clr,
    input  logic                  wide,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  rd_lo,
    input  logic                  flag_clr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [2*BYTE_W-1:0]   count_o,
    output logic [BYTE_W-1:0]     hbuf_o,
    output logic                  flag_o,
    output logic                  cnt_wr
);

    localparam int CNT_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_q, hi_q, hbuf_q;
    logic              flag_q;
    logic              wrap;

    assign count_o = {hi_q, lo_q};
    assign hbuf_o  = hbuf_q;
    assign flag_o  = flag_q;
    assign cnt_wr  = wr_lo | (wr_hi & ~wide);
    assign wrap    = inc && (count_o == {CNT_W{1'b1}}) && !cnt_wr && !sev_clr;

    // Purpose: update the count by write, clear or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (cnt_wr) begin
            if (wr_lo) begin
                lo_q <= wdata;
                if (wide) hi_q <= hbuf_q;
            end else begin
                hi_q <= wdata;
            end
        end else if (sev_clr) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (inc) begin
            {hi_q, lo_q} <= count_o + 1'b1;
        end
    end

    // Purpose: sticky overflow flag; a wrap wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (wrap)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Purpose: high-byte buffer for wide-mode writes and low-byte reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                hbuf_q <= '0;
        else if (wide && wr_hi)    hbuf_q <= wdata;
        else if (wide && rd_lo)    hbuf_q <= hi_q;
    end

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (flag_o && count_o == '0));                           // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !flag_clr) |=> flag_o);                             // R6
    AST_SEV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sev_clr && !cnt_wr) |=> count_o == '0);                       // R7
    AST_SEV_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (sev_clr && !cnt_wr && !flag_o) |=> !flag_o);                  // R7
    AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && wr_lo) |=> count_o == {$past(hbuf_o), $past(wdata)});  // R8
    AST_WIDE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && rd_lo && !wr_hi) |=> hbuf_o == $past(count_o[CNT_W-1:BYTE_W])); // R9
    AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wide) |=> count_o[BYTE_W-1:0] == $past(wdata));     // R11

endmodule

// File: rtl/ptmr16.sv
// Top: prescaled 16-bit timer/counter with a 4-address register window.
// Holds the control register, decodes bus strobes, and muxes read data.
// Assumes BYTE_W >= the control register width (6).
module ptmr16 #(
    parameter int BYTE_W   = 8,
    parameter int TICK_DIV = 4,
    parameter int PS_SEL_W = 2,
    parameter int SYNC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_i,
    input  logic              sev_clr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    output logic [BYTE_W-1:0] reg_rdata_o,
    output logic              ovf_flag_o
);
    import ptmr_pkg::*;

    localparam int CNT_W = 2 * BYTE_W;

    ctrl_t              ctrl_q;
    logic               wr_ctrl, wr_lo, wr_hi, wr_stat, rd_lo;
    logic               src_tick, ps_tick, cnt_wr;
    logic [CNT_W-1:0]   count;
    logic [BYTE_W-1:0]  hbuf;
    logic               flag;

    assign wr_ctrl = reg_wr_i && (reg_addr_i == ADR_CTRL);
    assign wr_lo   = reg_wr_i && (reg_addr_i == ADR_LO);
    assign wr_hi   = reg_wr_i && (reg_addr_i == ADR_HI);
    assign wr_stat = reg_wr_i && (reg_addr_i == ADR_STAT);
    assign rd_lo   = reg_rd_i && (reg_addr_i == ADR_LO);

    // Purpose: hold the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    end

    ptmr_clksel #(.TICK_DIV(TICK_DIV), .SYNC_W(SYNC_W)) u_clksel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_i     (ext_clk_i),
        .run       (ctrl_q.run),
        .ext_sel   (ctrl_q.ext_sel),
        .async_sel (ctrl_q.async_sel),
        .restart   (cnt_wr),
        .src_tick  (src_tick)
    );

    ptmr_prescale #(.PS_SEL_W(PS_SEL_W)) u_ps (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (src_tick),
        .sel     (ctrl_q.ps[PS_SEL_W-1:0]),
        .restart (cnt_wr),
        .tick_o  (ps_tick)
    );

    ptmr_core #(.BYTE_W(BYTE_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (ps_tick),
        .sev_clr  (sev_clr_i),
        .wide     (ctrl_q.wide),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .rd_lo    (rd_lo),
        .flag_clr (wr_stat),
        .wdata    (reg_wdata_i),
        .count_o  (count),
        .hbuf_o   (hbuf),
        .flag_o   (flag),
        .cnt_wr   (cnt_wr)
    );

    assign ovf_flag_o = flag;

    // Purpose: read data for the addressed register.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADR_CTRL: reg_rdata_o[CTRL_W-1:0] = ctrl_q;
            ADR_LO:   reg_rdata_o = count[BYTE_W-1:0];
            ADR_HI:   reg_rdata_o = ctrl_q.wide ? hbuf : count[CNT_W-1:BYTE_W];
            default:  reg_rdata_o[0] = flag;
        endcase
    end

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !cnt_wr && !sev_clr_i) |=> $stable(count));    // R4
    AST_HI_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !ctrl_q.wide) |=> count[CNT_W-1:BYTE_W] == $past(reg_wdata_i)); // R10

endmodule

// File: tb/tb_ptmr16.sv
`timescale 1ns/1ps
module tb_ptmr16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_i = 1'b0;
    logic       sev_clr_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd0;
    logic       reg_wr_i = 1'b0;
    logic       reg_rd_i = 1'b0;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic       ovf_flag_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    localparam logic [1:0] A_CTRL = 2'd0, A_LO = 2'd1, A_HI = 2'd2, A_STAT = 2'd3;

    always #2.5 clk = ~clk;

    ptmr16 dut (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .sev_clr_i(sev_clr_i),
        .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .ovf_flag_o(ovf_flag_o)
    );

    // Monitor: pop the expected item for each read strobe and compare.
    always @(negedge clk) begin
        if (reg_rd_i) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL scoreboard: read with no expected item, actual %02h expected none", reg_rdata_o);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_vec++;
                if (reg_rdata_o !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", t, reg_rdata_o, e);
                end
            end
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(posedge clk); #1;
        reg_wr_i = 1'b0;
    endtask

    // Driver: push the expected value, then issue the read.
    task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        reg_addr_i = a; reg_rd_i = 1'b1;
        @(posedge clk); #1;
        reg_rd_i = 1'b0;
    endtask

    task automatic ext_pulse();
        @(posedge clk); #1 ext_clk_i = 1'b1;
        repeat (3) @(posedge clk);
        #1 ext_clk_i = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic load16(input logic [7:0] h, input logic [7:0] l);
        bus_wr(A_HI, h);
        bus_wr(A_LO, l);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        bus_rd(A_CTRL, 8'h00, "R1 ctrl");
        bus_rd(A_LO,   8'h00, "R1 low");
        bus_rd(A_HI,   8'h00, "R1 high");
        bus_rd(A_STAT, 8'h00, "R1 status");

        // R2: internal tick, divide by 1: 40 clocks -> 10
        bus_wr(A_CTRL, 8'h01);
        load16(8'h00, 8'h00);
        repeat (38) @(posedge clk);
        bus_wr(A_CTRL, 8'h00);
        bus_rd(A_LO, 8'd10, "R2 internal count");
        bus_rd(A_HI, 8'd0,  "R2 internal high");

        // R3: code 1 (divide by 2): 40 clocks -> 5
        bus_wr(A_CTRL, 8'h09);
        bus_wr(A_LO, 8'h00);
        repeat (38) @(posedge clk);
        bus_wr(A_CTRL, 8'h00);
        bus_rd(A_LO, 8'd5, "R3 prescale code 1");

        // R3: code 3 (divide by 8): 64 clocks -> 2
        bus_wr(A_CTRL, 8'h19);
        bus_wr(A_LO, 8'h00);
        repeat (62) @(posedge clk);
        bus_wr(A_CTRL, 8'h00);
        bus_rd(A_LO, 8'd2, "R3 prescale code 3");

        // R4: run off, internal and external sources ignored
        bus_wr(A_LO, 8'h07);
        repeat (40) @(posedge clk);
        bus_rd(A_LO, 8'h07, "R4 hold internal");
        bus_wr(A_CTRL, 8'h02);
        ext_pulse(); ext_pulse();
        bus_rd(A_LO, 8'h07, "R4 hold external");

        // R5: synchronized path latency
        bus_wr(A_CTRL, 8'h03);
        load16(8'h00, 8'h00);
        repeat (3) @(posedge clk);
        @(posedge clk); #1 ext_clk_i = 1'b1;
        @(posedge clk);
        bus_rd(A_LO, 8'd0, "R5 sync not yet");
        bus_rd(A_LO, 8'd1, "R5 sync counted");
        #1 ext_clk_i = 1'b0;
        repeat (4) @(posedge clk);

        // R5: unsynchronized path is one clock earlier
        bus_wr(A_CTRL, 8'h07);
        load16(8'h00, 8'h00);
        repeat (3) @(posedge clk);
        @(posedge clk); #1 ext_clk_i = 1'b1;
        @(posedge clk);
        bus_rd(A_LO, 8'd1, "R5 async early");
        bus_rd(A_LO, 8'd1, "R5 async single");
        #1 ext_clk_i = 1'b0;
        repeat (4) @(posedge clk);

        // R3 + R5: external source, code 2 (divide by 4): 8 edges -> 2
        bus_wr(A_CTRL, 8'h13);
        load16(8'h00, 8'h00);
        for (int i = 0; i < 8; i++) ext_pulse();
        repeat (4) @(posedge clk);
        bus_rd(A_LO, 8'd2, "R3 external divide by 4");

        // R11: a counter write restarts the prescaler (code 1, async path)
        bus_wr(A_CTRL, 8'h0F);
        load16(8'h00, 8'h00);
        ext_pulse();
        bus_rd(A_LO, 8'h00, "R11 half period pending");
        bus_wr(A_LO, 8'h10);
        ext_pulse();
        bus_rd(A_LO, 8'h10, "R11 prescaler restarted");
        ext_pulse();
        bus_rd(A_LO, 8'h11, "R11 full period after restart");

        // R11: a write in the same cycle as an increment wins
        bus_wr(A_CTRL, 8'h07);
        bus_wr(A_LO, 8'h3F);
        @(posedge clk); #1 ext_clk_i = 1'b1;
        bus_wr(A_LO, 8'h40);
        repeat (3) @(posedge clk);
        #1 ext_clk_i = 1'b0;
        repeat (3) @(posedge clk);
        bus_rd(A_LO, 8'h40, "R11 write beats increment");

        // R6: wrap sets the flag, flag is sticky, a status write clears it
        load16(8'hFF, 8'hFF);
        ext_pulse();
        bus_rd(A_STAT, 8'h01, "R6 flag on wrap");
        bus_rd(A_LO,   8'h00, "R6 low after wrap");
        bus_rd(A_HI,   8'h00, "R6 high after wrap");
        repeat (10) @(posedge clk);
        bus_rd(A_STAT, 8'h01, "R6 flag sticky");
        if (ovf_flag_o !== 1'b1) begin
            n_bad++;
            $display("FAIL R6 flag pin: actual %0b expected 1", ovf_flag_o);
        end
        n_vec++;
        bus_wr(A_STAT, 8'h00);
        bus_rd(A_STAT, 8'h00, "R6 flag cleared");

        // R7: special-event clear, flag untouched
        bus_wr(A_CTRL, 8'h00);
        load16(8'h12, 8'h34);
        @(posedge clk); #1 sev_clr_i = 1'b1;
        @(posedge clk); #1 sev_clr_i = 1'b0;
        bus_rd(A_LO,   8'h00, "R7 clear low");
        bus_rd(A_HI,   8'h00, "R7 clear high");
        bus_rd(A_STAT, 8'h00, "R7 no flag");

        // R7: a write in the same cycle wins over the clear
        load16(8'h12, 8'h34);
        @(posedge clk); #1;
        sev_clr_i = 1'b1; reg_addr_i = A_LO; reg_wdata_i = 8'h55; reg_wr_i = 1'b1;
        @(posedge clk); #1;
        sev_clr_i = 1'b0; reg_wr_i = 1'b0;
        bus_rd(A_HI, 8'h12, "R7 write wins high");
        bus_rd(A_LO, 8'h55, "R7 write wins low");

        // R8 + R9: wide mode buffering (count is 0x1255)
        bus_wr(A_CTRL, 8'h20);
        bus_wr(A_HI, 8'hAB);
        bus_rd(A_HI, 8'hAB, "R9 high read returns buffer");
        bus_rd(A_LO, 8'h55, "R8 high write left count");
        bus_rd(A_HI, 8'h12, "R9 low read latched live high");
        bus_wr(A_HI, 8'hCD);
        bus_wr(A_LO, 8'hEF);
        bus_wr(A_CTRL, 8'h00);
        bus_rd(A_HI, 8'hCD, "R8 atomic load high");
        bus_rd(A_LO, 8'hEF, "R8 atomic load low");

        // R10: narrow mode acts on live halves
        bus_wr(A_HI, 8'h5A);
        bus_rd(A_HI, 8'h5A, "R10 direct high");
        bus_rd(A_LO, 8'hEF, "R10 low untouched");

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finish_up();
    end

endmodule